// File: doc/BRIEF.md
# Multi-way address translation lookup with ring checking

This block translates a 32-bit virtual address through seven ways of translation entries and reports either a physical address or a fault cause. Ways 0 to 3 hold 4 KB pages. Way 4 has a page size chosen at run time. Ways 5 and 6 hold large pages, and a build parameter makes their size either fixed or chosen at run time. For every way, the block computes the entry index from the address bits that sit just above that way's current page offset. It then compares the stored virtual page, and counts the entry only if its address-space identifier is nonzero and appears in one of the four bytes of the ring-identifier word. The position of that byte is the ring of the entry.

One lookup is accepted per cycle and the result is registered, so it appears one cycle after the request. Faults are ranked in this order: more than one hit, no hit, insufficient privilege, then access not permitted. An entry write port loads one way per cycle, and the lookup logic uses the same indexing for writes. Refill policy lives outside the block.

Top module: `tlb_lookup`

## Requirements
- R1: After reset, rsp_valid is 0 and every entry is invalid, so any lookup reports a miss.
- R2: Each request with req_valid high produces rsp_valid high in the next cycle. rsp_valid is low in a cycle that follows a cycle without a request.
- R3: Page size (log2) per way: ways 0 to 3 use 12, way 4 uses 20 + 2·way4_size, way 5 uses 27 + way5_size, and way 6 uses 29 − way6_size. With VAR56 = 0, way 5 uses 27 and way 6 uses 28. The entry index is taken from the bits starting at the page-size bit position, with these widths: SMALL_IBITS bits in ways 0 to 3, 2 bits in way 4, 2 bits in way 5 (1 when fixed), and 3 bits in way 6 (1 when fixed).
- R4: An entry hits only when all of these hold: its stored page equals the address under the way mask, its identifier is nonzero, and the identifier matches a byte of ring_asids. The ring is the lowest byte index that matches, where byte i is bits [8i+7:8i]. An identifier that is in no byte never hits.
- R5: Two or more hits give cause 17 for a fetch and 25 for a load or store. This is the highest-priority fault.
- R6: Zero hits give cause 16 for a fetch and 24 for a load or store. req_kind encodes the access as follows: 0 is a load, 1 is a store, and 2 or 3 is a fetch.
- R7: A single hit whose ring is lower than cur_ring gives cause 18 for a fetch and 26 for data.
- R8: Attribute decode: values 0 to 11 grant read, with bit 0 adding execute and bit 1 adding write. Value 13 grants read and write. All other values grant nothing. Data accesses never use execute, and fetches use only execute. A denied access gives cause 20 for a fetch, 28 for a load and 29 for a store.
- R9: On success, rsp_fault is 0, rsp_cause is 0, rsp_pa is the stored physical page ORed with the address bits below the page size, and rsp_page_log2 is the page size. On any fault, rsp_pa and rsp_page_log2 are 0.
- R10: A write and a lookup in the same cycle: the lookup sees the contents from before the write, and the written entry is visible from the next cycle on. Stored virtual and physical pages are masked to the way's page size at write time.
- R11: With VAR56 = 0, the fixed sizes and index widths of ways 5 and 6 from R3 apply whatever way5_size and way6_size are set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| cur_ring | input | 2 | Current privilege ring |
| ring_asids | input | 32 | Byte i holds the identifier of ring i |
| way4_size | input | 2 | Page-size select of way 4 |
| way5_size | input | 1 | Page-size select of way 5 (run-time mode) |
| way6_size | input | 1 | Page-size select of way 6 (run-time mode) |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 3 | Way to write (7 writes nothing) |
| wr_va | input | 32 | Virtual address giving page and index |
| wr_pa | input | 32 | Physical page address |
| wr_asid | input | 8 | Identifier; 0 invalidates |
| wr_attr | input | 4 | Access attribute |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Result is a fault |
| rsp_cause | output | 5 | Fault cause, 0 on success |
| rsp_pa | output | 32 | Physical address |
| rsp_page_log2 | output | 5 | log2 of the page size |

## Verification
An entry write and a lookup can fall in the same cycle and hit the same entry. The bench provokes this in a directed case and in many random cycles, in which writes and lookups share a small pool of addresses. It judges the result against a shadow model that resolves the lookup before applying the write. The result must show the old contents in that cycle and the new contents in the following cycle. Page-size changes are mixed in between writes, so entries written under one size are then looked up under another.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;

    localparam int NWAYS   = 7;
    localparam int VA_W    = 32;
    localparam int ASID_W  = 8;
    localparam int ATTR_W  = 4;
    localparam int RINGS   = 4;
    localparam int LOG2_W  = 5;
    localparam int CAUSE_W = 5;
    localparam int WAY_W   = 3;

    localparam logic [CAUSE_W-1:0] C_NONE      = 5'd0;
    localparam logic [CAUSE_W-1:0] C_I_MISS    = 5'd16;
    localparam logic [CAUSE_W-1:0] C_I_MULTI   = 5'd17;
    localparam logic [CAUSE_W-1:0] C_I_PRIV    = 5'd18;
    localparam logic [CAUSE_W-1:0] C_I_PROHIB  = 5'd20;
    localparam logic [CAUSE_W-1:0] C_D_MISS    = 5'd24;
    localparam logic [CAUSE_W-1:0] C_D_MULTI   = 5'd25;
    localparam logic [CAUSE_W-1:0] C_D_PRIV    = 5'd26;
    localparam logic [CAUSE_W-1:0] C_LD_PROHIB = 5'd28;
    localparam logic [CAUSE_W-1:0] C_ST_PROHIB = 5'd29;

    typedef struct packed {
        logic [1:0] w4;
        logic       w5;
        logic       w6;
    } pgcfg_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef struct packed {
        logic       found;
        logic [1:0] ring;
    } ring_find_t;

    typedef struct packed {
        logic              hit;
        logic [1:0]        ring;
        logic [VA_W-1:0]   ppn;
        logic [ATTR_W-1:0] attr;
        logic [LOG2_W-1:0] l2;
    } way_res_t;

    typedef struct packed {
        logic               fault;
        logic [CAUSE_W-1:0] cause;
        logic [VA_W-1:0]    pa;
        logic [LOG2_W-1:0]  l2;
    } lookup_res_t;

    // log2 of page size for a way under the current size selects
    function automatic logic [LOG2_W-1:0] way_log2(int way, bit var56, pgcfg_t c);
        int v;
        if (way < 4)       v = 12;
        else if (way == 4) v = 20 + 2 * int'(c.w4);
        else if (way == 5) v = var56 ? 27 + int'(c.w5) : 27;
        else               v = var56 ? 29 - int'(c.w6) : 28;
        return LOG2_W'(v);
    endfunction

    // number of index bits of a way
    function automatic int way_ibits(int way, bit var56, int small_ibits);
        if (way < 4)       return small_ibits;
        else if (way == 4) return 2;
        else if (way == 5) return var56 ? 2 : 1;
        else               return var56 ? 3 : 1;
    endfunction

    function automatic logic [VA_W-1:0] page_mask(logic [LOG2_W-1:0] l2);
        return {VA_W{1'b1}} << l2;
    endfunction

    function automatic rights_t attr_rights(logic [ATTR_W-1:0] a);
        rights_t r;
        r = '0;
        if (a < 4'd12) begin
            r.rd = 1'b1;
            r.ex = a[0];
            r.wr = a[1];
        end else if (a == 4'd13) begin
            r.rd = 1'b1;
            r.wr = 1'b1;
        end
        return r;
    endfunction

    // lowest ring whose identifier byte equals the given identifier
    function automatic ring_find_t ring_of(logic [ASID_W-1:0] asid,
                                           logic [RINGS*ASID_W-1:0] regs);
        ring_find_t f;
        f = '0;
        for (int i = RINGS - 1; i >= 0; i--) begin
            if (regs[i*ASID_W +: ASID_W] == asid) begin
                f.found = 1'b1;
                f.ring  = 2'(i);
            end
        end
        return f;
    endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_lookup_pkg::*;
#(
    parameter int WAY         = 0,
    parameter bit VAR56       = 1'b1,
    parameter int SMALL_IBITS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  pgcfg_t                  cfg,
    input  logic                    wr_en,
    input  logic [VA_W-1:0]         wr_va,
    input  logic [VA_W-1:0]         wr_pa,
    input  logic [ASID_W-1:0]       wr_asid,
    input  logic [ATTR_W-1:0]       wr_attr,
    input  logic [VA_W-1:0]         lk_va,
    input  logic [RINGS*ASID_W-1:0] ring_asids,
    output way_res_t                res
);
    localparam int IBITS = way_ibits(WAY, VAR56, SMALL_IBITS);
    localparam int DEPTH = 1 << IBITS;

    logic [LOG2_W-1:0] l2;
    logic [VA_W-1:0]   mask;
    logic [IBITS-1:0]  wr_idx;
    logic [IBITS-1:0]  lk_idx;

    logic [VA_W-1:0]   vpn_q  [DEPTH];
    logic [VA_W-1:0]   ppn_q  [DEPTH];
    logic [ASID_W-1:0] asid_q [DEPTH];
    logic [ATTR_W-1:0] attr_q [DEPTH];

    assign l2     = way_log2(WAY, VAR56, cfg);
    assign mask   = page_mask(l2);
    assign wr_idx = IBITS'(wr_va >> l2);
    assign lk_idx = IBITS'(lk_va >> l2);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) asid_q[i] <= '0;
        end else if (wr_en) begin
            asid_q[wr_idx] <= wr_asid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            vpn_q[wr_idx]  <= wr_va & mask;
            ppn_q[wr_idx]  <= wr_pa & mask;
            attr_q[wr_idx] <= wr_attr;
        end
    end

    ring_find_t rf;
    logic [ASID_W-1:0] e_asid;

    always_comb begin
        e_asid   = asid_q[lk_idx];
        rf       = ring_of(e_asid, ring_asids);
        res.hit  = (e_asid != '0) && rf.found && (vpn_q[lk_idx] == (lk_va & mask));
        res.ring = rf.ring;
        res.ppn  = ppn_q[lk_idx];
        res.attr = attr_q[lk_idx];
        res.l2   = l2;
    end

endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
    import tlb_lookup_pkg::*;
(
    input  way_res_t          ways [NWAYS],
    input  logic [VA_W-1:0]   va,
    input  logic [1:0]        kind,
    input  logic [1:0]        cur_ring,
    output lookup_res_t       res
);
    logic [NWAYS-1:0] hits;
    way_res_t         sel;
    rights_t          rt;
    logic             fetch;
    logic             store;
    logic             granted;

    always_comb begin
        sel = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            hits[w] = ways[w].hit;
            if (ways[w].hit) sel = ways[w];
        end
        fetch = kind[1];
        store = (kind == 2'd1);
        rt    = attr_rights(sel.attr);
        if (fetch) begin
            rt.rd = 1'b0;
            rt.wr = 1'b0;
        end else begin
            rt.ex = 1'b0;
        end
        granted = fetch ? rt.ex : (store ? rt.wr : rt.rd);

        res = '0;
        res.fault = 1'b1;
        if ($countones(hits) > 1) begin
            res.cause = fetch ? C_I_MULTI : C_D_MULTI;
        end else if (hits == '0) begin
            res.cause = fetch ? C_I_MISS : C_D_MISS;
        end else if (sel.ring < cur_ring) begin
            res.cause = fetch ? C_I_PRIV : C_D_PRIV;
        end else if (!granted) begin
            res.cause = fetch ? C_I_PROHIB : (store ? C_ST_PROHIB : C_LD_PROHIB);
        end else begin
            res.fault = 1'b0;
            res.cause = C_NONE;
            res.pa    = sel.ppn | (va & ~page_mask(sel.l2));
            res.l2    = sel.l2;
        end
    end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_lookup_pkg::*;
#(
    parameter bit VAR56       = 1'b1,
    parameter int SMALL_IBITS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [31:0]         req_va,
    input  logic [1:0]          req_kind,
    input  logic [1:0]          cur_ring,
    input  logic [31:0]         ring_asids,
    input  logic [1:0]          way4_size,
    input  logic                way5_size,
    input  logic                way6_size,
    input  logic                wr_en,
    input  logic [2:0]          wr_way,
    input  logic [31:0]         wr_va,
    input  logic [31:0]         wr_pa,
    input  logic [7:0]          wr_asid,
    input  logic [3:0]          wr_attr,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [4:0]          rsp_cause,
    output logic [31:0]         rsp_pa,
    output logic [4:0]          rsp_page_log2
);
    pgcfg_t      cfg;
    way_res_t    way_res [NWAYS];
    lookup_res_t nxt;
    lookup_res_t res_q;

    assign cfg = '{w4: way4_size, w5: way5_size, w6: way6_size};

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        tlb_way #(
            .WAY         (w),
            .VAR56       (VAR56),
            .SMALL_IBITS (SMALL_IBITS)
        ) u_way (
            .clk        (clk),
            .rst        (rst),
            .cfg        (cfg),
            .wr_en      (wr_en && (wr_way == WAY_W'(w))),
            .wr_va      (wr_va),
            .wr_pa      (wr_pa),
            .wr_asid    (wr_asid),
            .wr_attr    (wr_attr),
            .lk_va      (req_va),
            .ring_asids (ring_asids),
            .res        (way_res[w])
        );
    end

    tlb_resolve u_resolve (
        .ways     (way_res),
        .va       (req_va),
        .kind     (req_kind),
        .cur_ring (cur_ring),
        .res      (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) res_q <= nxt;
        end
    end

    assign rsp_fault     = res_q.fault;
    assign rsp_cause     = res_q.cause;
    assign rsp_pa        = res_q.pa;
    assign rsp_page_log2 = res_q.l2;

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [4:0]  rsp_cause,
    input logic [31:0] rsp_pa,
    input logic [4:0]  rsp_page_log2
);
    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R2
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R9
    a_r9_fault_zeroes: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_pa == 32'd0 && rsp_page_log2 == 5'd0));
    // R9
    a_r9_ok_cause_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 5'd0));
    // R3
    a_r3_legal_size: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_page_log2 inside {5'd12, 5'd20, 5'd22,
                                        5'd24, 5'd26, 5'd27, 5'd28, 5'd29}));
    // R6: fetch faults use the low cause group, data faults the high one
    a_r6_cause_side: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> ((rsp_cause < 5'd24) == $past(req_kind[1])));
endmodule

bind tlb_lookup tlb_lookup_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause),
    .rsp_pa        (rsp_pa),
    .rsp_page_log2 (rsp_page_log2)
);

// File: tb/tlb_lookup_bench.sv
`timescale 1ns/1ps
module tlb_lookup_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  cur_ring = '0;
    logic [31:0] ring_asids = 32'h04030201;
    logic [1:0]  way4_size = '0;
    logic        way5_size = 1'b0;
    logic        way6_size = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_way = '0;
    logic [31:0] wr_va = '0;
    logic [31:0] wr_pa = '0;
    logic [7:0]  wr_asid = '0;
    logic [3:0]  wr_attr = '0;

    logic        rsp_valid, rsp_fault;
    logic [4:0]  rsp_cause, rsp_page_log2;
    logic [31:0] rsp_pa;
    logic        f_valid, f_fault;
    logic [4:0]  f_cause, f_l2;
    logic [31:0] f_pa;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    tlb_lookup u_tlb_lookup (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_kind(req_kind), .cur_ring(cur_ring), .ring_asids(ring_asids),
        .way4_size(way4_size), .way5_size(way5_size), .way6_size(way6_size),
        .wr_en(wr_en), .wr_way(wr_way), .wr_va(wr_va), .wr_pa(wr_pa),
        .wr_asid(wr_asid), .wr_attr(wr_attr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_pa(rsp_pa), .rsp_page_log2(rsp_page_log2)
    );

    tlb_lookup #(.VAR56(1'b0)) u_tlb_lookup_fixed (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_kind(req_kind), .cur_ring(cur_ring), .ring_asids(ring_asids),
        .way4_size(way4_size), .way5_size(way5_size), .way6_size(way6_size),
        .wr_en(wr_en), .wr_way(wr_way), .wr_va(wr_va), .wr_pa(wr_pa),
        .wr_asid(wr_asid), .wr_attr(wr_attr),
        .rsp_valid(f_valid), .rsp_fault(f_fault), .rsp_cause(f_cause),
        .rsp_pa(f_pa), .rsp_page_log2(f_l2)
    );

    // shadow contents, first index: 1 run-time ways 5/6, 0 fixed
    logic [31:0] m_vpn  [2][7][8];
    logic [31:0] m_ppn  [2][7][8];
    logic [7:0]  m_asid [2][7][8];
    logic [3:0]  m_attr [2][7][8];

    function automatic int b_log2(int way, int v);
        if (way < 4)       return 12;
        if (way == 4)      return 20 + 2 * int'(way4_size);
        if (way == 5)      return v ? 27 + int'(way5_size) : 27;
        return v ? 29 - int'(way6_size) : 28;
    endfunction

    function automatic int b_ibits(int way, int v);
        if (way <= 4) return 2;
        if (way == 5) return v ? 2 : 1;
        return v ? 3 : 1;
    endfunction

    function automatic logic [43:0] model(int v, logic [31:0] va, logic [1:0] kind,
                                          logic [1:0] cr);
        int nh = 0;
        int sw = 0;
        int sr = 0;
        int se = 0;
        logic rd, wr, ex, ok;
        logic [3:0] a;
        for (int w = 0; w < 7; w++) begin
            int l2 = b_log2(w, v);
            int ix = int'((va >> l2) & ((32'd1 << b_ibits(w, v)) - 1));
            logic [31:0] m = 32'hFFFF_FFFF << l2;
            if (m_asid[v][w][ix] != 8'd0 && m_vpn[v][w][ix] == (va & m)) begin
                int rg = -1;
                for (int i = 3; i >= 0; i--)
                    if (ring_asids[i*8 +: 8] == m_asid[v][w][ix]) rg = i;
                if (rg >= 0) begin
                    if (nh == 0) begin sw = w; sr = rg; se = ix; end
                    nh++;
                end
            end
        end
        if (nh > 1)  return {1'b1, 1'b1, kind[1] ? 5'd17 : 5'd25, 32'd0, 5'd0};
        if (nh == 0) return {1'b1, 1'b1, kind[1] ? 5'd16 : 5'd24, 32'd0, 5'd0};
        if (sr < int'(cr)) return {1'b1, 1'b1, kind[1] ? 5'd18 : 5'd26, 32'd0, 5'd0};
        a  = m_attr[v][sw][se];
        rd = (a < 4'd12) || (a == 4'd13);
        wr = ((a < 4'd12) && a[1]) || (a == 4'd13);
        ex = (a < 4'd12) && a[0];
        ok = kind[1] ? ex : (kind == 2'd1 ? wr : rd);
        if (!ok)
            return {1'b1, 1'b1, kind[1] ? 5'd20 : (kind == 2'd1 ? 5'd29 : 5'd28),
                    32'd0, 5'd0};
        begin
            int l2 = b_log2(sw, v);
            logic [31:0] m = 32'hFFFF_FFFF << l2;
            return {1'b1, 1'b0, 5'd0, m_ppn[v][sw][se] | (va & ~m), 5'(l2)};
        end
    endfunction

    function automatic string tag_of(logic [43:0] e);
        case (e[41:37])
            5'd17, 5'd25: return "R5";
            5'd16, 5'd24: return "R6";
            5'd18, 5'd26: return "R7";
            5'd20, 5'd28, 5'd29: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [43:0] act, logic [43:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check at the next negedge
    task automatic op(string tag, bit do_req, logic [31:0] va, logic [1:0] kind,
                      logic [1:0] cr, bit do_wr, int wway, logic [31:0] wva,
                      logic [31:0] wpa, logic [7:0] wasid, logic [3:0] wattr);
        logic [43:0] e1, e0;
        req_valid = do_req; req_va = va; req_kind = kind; cur_ring = cr;
        wr_en = do_wr; wr_way = 3'(wway); wr_va = wva; wr_pa = wpa;
        wr_asid = wasid; wr_attr = wattr;
        e1 = model(1, va, kind, cr);
        e0 = model(0, va, kind, cr);
        if (do_wr && wway < 7) begin
            for (int v = 0; v < 2; v++) begin
                int l2 = b_log2(wway, v);
                int ix = int'((wva >> l2) & ((32'd1 << b_ibits(wway, v)) - 1));
                logic [31:0] m = 32'hFFFF_FFFF << l2;
                m_vpn[v][wway][ix]  = wva & m;
                m_ppn[v][wway][ix]  = wpa & m;
                m_asid[v][wway][ix] = wasid;
                m_attr[v][wway][ix] = wattr;
            end
        end
        @(negedge clk);
        if (do_req) begin
            check(tag == "" ? tag_of(e1) : tag,
                  {rsp_valid, rsp_fault, rsp_cause, rsp_pa, rsp_page_log2}, e1);
            check("R11", {f_valid, f_fault, f_cause, f_pa, f_l2}, e0);
        end else begin
            check("R2", {43'd0, rsp_valid}, 44'd0);
        end
        req_valid = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic wr(int w, logic [31:0] va, logic [31:0] pa, logic [7:0] as,
                      logic [3:0] at);
        op("", 1'b0, 32'd0, 2'd0, 2'd0, 1'b1, w, va, pa, as, at);
    endtask

    task automatic rd(string tag, logic [31:0] va, logic [1:0] kind, logic [1:0] cr);
        op(tag, 1'b1, va, kind, cr, 1'b0, 0, 32'd0, 32'd0, 8'd0, 4'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] pool [16];
        void'($urandom(32'd20240611));
        for (int v = 0; v < 2; v++)
            for (int w = 0; w < 7; w++)
                for (int i = 0; i < 8; i++) begin
                    m_asid[v][w][i] = 8'd0; m_vpn[v][w][i] = '0;
                    m_ppn[v][w][i] = '0; m_attr[v][w][i] = '0;
                end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state and empty contents
        check("R1", {43'd0, rsp_valid}, 44'd0);
        rd("R1", 32'h1234_5678, 2'd0, 2'd0);
        rd("R1", 32'hD000_0000, 2'd2, 2'd0);

        // R3: way 4 with size select 2 (16 MB pages)
        way4_size = 2'd2;
        wr(4, 32'h1234_5000, 32'hAB00_0000, 8'h01, 4'd4);
        rd("R3", 32'h12AB_CDEF, 2'd0, 2'd0);
        way4_size = 2'd0;
        rd("R3", 32'h12AB_CDEF, 2'd0, 2'd0);
        way4_size = 2'd2;
        // R3 / R11: ways 5 and 6 under both size selects
        way5_size = 1'b1; way6_size = 1'b0;
        wr(5, 32'hD800_0000, 32'h4000_0000, 8'h02, 4'd5);
        wr(6, 32'hE000_0000, 32'hF000_0000, 8'h01, 4'd3);
        rd("R3", 32'hD812_3456, 2'd2, 2'd0);
        rd("R3", 32'hE765_4321, 2'd0, 2'd0);
        way5_size = 1'b0; way6_size = 1'b1;
        rd("R3", 32'hD812_3456, 2'd2, 2'd0);
        rd("R3", 32'hE765_4321, 2'd1, 2'd0);

        // R4: identifier search order and absent identifier
        wr(0, 32'h0000_3000, 32'h0009_9000, 8'h05, 4'd7);
        ring_asids = 32'h0505_0505;
        rd("R4", 32'h0000_3ABC, 2'd1, 2'd0);
        rd("R4", 32'h0000_3ABC, 2'd1, 2'd1);
        ring_asids = 32'h0506_0708;
        rd("R4", 32'h0000_3ABC, 2'd0, 2'd3);
        ring_asids = 32'h0403_0201;
        rd("R4", 32'h0000_3ABC, 2'd0, 2'd0);
        // R7: ring 0 entry, ring 2 access
        ring_asids = 32'h0807_0605;
        rd("R7", 32'h0000_3ABC, 2'd2, 2'd2);
        ring_asids = 32'h0403_0201;

        // R5: same page in two ways
        wr(1, 32'h0000_3000, 32'h0001_1000, 8'h01, 4'd7);
        wr(2, 32'h0000_3000, 32'h0002_2000, 8'h02, 4'd7);
        rd("R5", 32'h0000_3010, 2'd0, 2'd0);
        rd("R5", 32'h0000_3010, 2'd2, 2'd0);
        wr(2, 32'h0000_3000, 32'h0002_2000, 8'h00, 4'd7);

        // R8: attribute decode per access kind
        wr(3, 32'h0004_5000, 32'h7000_0000, 8'h01, 4'd4);
        rd("R8", 32'h0004_5004, 2'd1, 2'd0);
        rd("R8", 32'h0004_5004, 2'd3, 2'd0);
        rd("R9", 32'h0004_5004, 2'd0, 2'd0);
        wr(3, 32'h0004_5000, 32'h7000_0000, 8'h01, 4'd13);
        rd("R8", 32'h0004_5004, 2'd1, 2'd0);
        rd("R8", 32'h0004_5004, 2'd2, 2'd0);
        wr(3, 32'h0004_5000, 32'h7000_0000, 8'h01, 4'd14);
        rd("R8", 32'h0004_5004, 2'd0, 2'd0);

        // R10: write and lookup of the same entry in one cycle
        op("R10", 1'b1, 32'h7777_7123, 2'd0, 2'd0, 1'b1, 3,
           32'h7777_7000, 32'h0123_4000, 8'h01, 4'd4);
        rd("R10", 32'h7777_7123, 2'd0, 2'd0);

        // random phase
        for (int i = 0; i < 16; i++) pool[i] = $urandom;
        for (int n = 0; n < 3000; n++) begin
            bit dw, dr;
            logic [31:0] va, wva;
            if (n % 200 == 0) begin
                way4_size = 2'($urandom_range(3));
                way5_size = 1'($urandom_range(1));
                way6_size = 1'($urandom_range(1));
            end
            if (n % 50 == 0)
                for (int b = 0; b < 4; b++)
                    ring_asids[b*8 +: 8] = 8'($urandom_range(5, 1));
            dw  = ($urandom_range(9) < 4);
            dr  = ($urandom_range(9) < 8);
            wva = pool[$urandom_range(15)];
            va  = ($urandom_range(9) == 0) ? $urandom
                  : (pool[$urandom_range(15)] ^ ($urandom & 32'h0000_0FFF));
            op("", dr, va, 2'($urandom_range(3)), 2'($urandom_range(3)),
               dw, $urandom_range(6), wva, $urandom,
               8'($urandom_range(5)), 4'($urandom_range(15)));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule